// File: doc/BRIEF.md
# Pin Interrupt Status Unit

This block watches eight already-selected input pins and raises one interrupt line per pin. Each channel is set up either to trigger on signal transitions or to follow a signal level. A transition channel keeps a sticky record of rising and falling events, and each direction has its own enable. A level channel asserts while the pin matches a programmable polarity. It keeps no memory of past values.

Software sees four word registers through single-cycle write and read strobes. A mode mask picks transition or level per channel. A rise mask gives the rising-event enable in transition mode and the level enable in level mode. A fall mask gives the falling-event enable in transition mode and the active polarity in level mode. The status word shows the live request of every channel. Writing ones to status acknowledges transition channels. On level channels the same write toggles the active polarity, so a handler can wait for the pin to return to its other value.

Top module: `pint_unit`

## Requirements
- R1: A read takes effect at the clock edge where `rd_en` is high, and `rdata` holds the result from the next edge on. Reading address 3 (status) returns the request of channel n in bit n for bits 7:0, and zeros in bits 31:8.
- R2: After reset the mode, rise and fall masks are all zero, every `irq_out` bit is 0, and status reads as zero.
- R3: A channel in transition mode (mode bit 0) with its rise bit at 1 records a 0-to-1 change of its pin. Its `irq_out` bit is 1 from the clock edge at which the new pin value is first sampled.
- R4: A channel in transition mode with its fall bit at 1 records a 1-to-0 change of its pin. The timing is the same as in R3.
- R5: A transition seen while the matching enable bit is 0 is not recorded. Setting the enable afterwards raises no request.
- R6: A recorded transition request stays asserted until software acknowledges it. This holds after the pin returns to its previous value.
- R7: Writing 1 to status bit n of a transition channel clears both its rising and falling records. The request drops at that edge.
- R8: Zero bits in a status write change neither requests nor the fall mask.
- R9: Writing 1 to status bit n of a level channel (mode bit 1) inverts bit n of the fall mask, which is visible at address 2. It clears nothing.
- R10: A level channel requests whenever its rise bit is 1 and its pin equals its fall-mask bit (the active polarity). The request follows the pin combinationally.
- R11: When a transition is detected at the same edge as a status write that clears that channel, the new transition is kept and the request stays 1.
- R12: The word addresses are 0 = mode mask (1 = level), 1 = rise mask, 2 = fall mask / active polarity, 3 = status. Bit n of each belongs to channel n. Addresses 0 to 2 read back what was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Synchronous pin inputs, one per channel |
| irq_out | output | 8 | Interrupt request per channel |

## Verification
Transition requests and register writes appear one clock edge after the pin change or strobe is sampled. Read data appears one edge after `rd_en`. Level requests follow the pin with no clock delay. The bench changes inputs shortly after a falling clock edge. It queues the expected value once the edge that should produce it has passed. The monitor compares the queued value at the next falling edge, so every comparison falls after the rising edge at which the result is due. The same-edge cases (R11, and the flip in R9) are driven in a single cycle, so the order in which the two effects land is what gets checked.

// File: rtl/pint_pkg.sv
// Shared constants and types for the pin interrupt status unit.
// Assumes a two-bit word address space holding four registers.
package pint_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE = 2'd0,
        REG_RISE = 2'd1,
        REG_FALL = 2'd2,
        REG_STAT = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pint_regs.sv
// Configuration registers: mode mask, rise mask and fall/polarity mask.
// A status write toggles the polarity bit of every level channel that has
// a 1 in the write data. Transition channels are cleared elsewhere.
// Assumes write strobes last one cycle.
module pint_regs
    import pint_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NCH-1:0]       wbits,
    output logic [NCH-1:0]       mode_q,
    output logic [NCH-1:0]       rise_q,
    output logic [NCH-1:0]       fall_q,
    output logic [NCH-1:0]       ack_mask
);

    logic sel_mode, sel_rise, sel_fall, sel_stat;

    // Decode which register the current write targets.
    always_comb begin
        sel_mode = wr_en && (addr == REG_MODE);
        sel_rise = wr_en && (addr == REG_RISE);
        sel_fall = wr_en && (addr == REG_FALL);
        sel_stat = wr_en && (addr == REG_STAT);
        ack_mask = sel_stat ? wbits : '0;
    end

    // Mode and rise masks load on a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rise_q <= '0;
        end else begin
            if (sel_mode) mode_q <= wbits;
            if (sel_rise) rise_q <= wbits;
        end
    end

    // The fall mask loads directly, or toggles on level-channel acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else if (sel_fall) begin
            fall_q <= wbits;
        end else if (sel_stat) begin
            fall_q <= fall_q ^ (wbits & mode_q);
        end
    end

endmodule

// File: rtl/pint_chan.sv
// One interrupt channel. In transition mode it keeps sticky rising and
// falling records, each set only while its enable is on. In level mode it
// requests while the pin matches the active polarity.
// Assumes pin is already synchronous to clk.
module pint_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    input  logic rise_en,
    input  logic fall_en,
    input  logic ack,
    output logic req
);

    logic pin_q;
    logic rise_seen, fall_seen;
    logic rise_evt, fall_evt;

    // Compare the pin with its previous sample to find transitions.
    always_comb begin
        rise_evt = pin & ~pin_q;
        fall_evt = ~pin & pin_q;
    end

    // Keep the previous pin sample.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    // Sticky records: a new transition wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || level_mode) begin
            rise_seen <= 1'b0;
            fall_seen <= 1'b0;
        end else begin
            rise_seen <= (rise_evt & rise_en) | (rise_seen & ~ack);
            fall_seen <= (fall_evt & fall_en) | (fall_seen & ~ack);
        end
    end

    // Request: live level compare, or enabled sticky records.
    always_comb begin
        if (level_mode) req = rise_en & (pin == fall_en);
        else            req = (rise_seen & rise_en) | (fall_seen & fall_en);
    end

endmodule

// File: rtl/pint_unit.sv
// Top of the pin interrupt status unit: register block, one channel per
// pin, and the registered read port. Unused high write-data bits are ignored.
module pint_unit
    import pint_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [NCH-1:0]       pin_in,
    output logic [NCH-1:0]       irq_out
);

    localparam int PAD_W = DW - NCH;

    logic [NCH-1:0] mode_r, rise_r, fall_r, ack_r;
    logic [NCH-1:0] sel_word;
    logic           unused_hi;

    assign unused_hi = ^wdata[DW-1:NCH];

    pint_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wbits    (wdata[NCH-1:0]),
        .mode_q   (mode_r),
        .rise_q   (rise_r),
        .fall_q   (fall_r),
        .ack_mask (ack_r)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pint_chan u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (pin_in[i]),
            .level_mode (mode_r[i]),
            .rise_en    (rise_r[i]),
            .fall_en    (fall_r[i]),
            .ack        (ack_r[i]),
            .req        (irq_out[i])
        );
    end

    // Choose the word a read returns.
    always_comb begin
        case (addr)
            REG_MODE: sel_word = mode_r;
            REG_RISE: sel_word = rise_r;
            REG_FALL: sel_word = fall_r;
            default:  sel_word = irq_out;
        endcase
    end

    // Capture read data on the read strobe, zero-extended.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= {{PAD_W{1'b0}}, sel_word};
    end

endmodule

// File: rtl/pint_unit_chk.sv
// Property checker for pint_unit, attached with bind.
module pint_unit_chk
    import pint_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [NCH-1:0]    pin_in,
    input logic [NCH-1:0]    irq_out,
    input logic [NCH-1:0]    mode_q,
    input logic [NCH-1:0]    rise_q,
    input logic [NCH-1:0]    fall_q
);

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:NCH] == '0);

    // R9
    level_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_STAT) |=> fall_q == $past(fall_q ^ (wdata[NCH-1:0] & mode_q)));

    // R8
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_STAT && wdata[NCH-1:0] == '0) |=> ($stable(fall_q) && $stable(mode_q)));

    for (genvar i = 0; i < NCH; i++) begin : g_p
        // R3
        rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(pin_in[i]) && !mode_q[i] && rise_q[i] && !wr_en) |=> irq_out[i]);

        // R6
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && !mode_q[i] && !wr_en) |=> irq_out[i]);

        // R7
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && wr_en && addr == REG_STAT && wdata[i] && !mode_q[i] && $stable(pin_in[i]))
            |=> !irq_out[i]);
    end

endmodule

bind pint_unit pint_unit_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_in  (pin_in),
    .irq_out (irq_out),
    .mode_q  (mode_r),
    .rise_q  (rise_r),
    .fall_q  (fall_r)
);

// File: tb/pint_unit_test.sv
`timescale 1ns/1ps
module pint_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  irq_out;

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    pint_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .irq_out(irq_out)
    );

    // Monitor: compare every queued expectation at the next falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_rd ? rdata : {24'd0, irq_out};
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Step to just after the falling edge and release the strobes.
    task automatic tick();
        @(negedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        tick();
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic set_pins(input logic [7:0] p);
        tick();
        pin_in = p;
    endtask

    task automatic exp_irq(input string tag, input logic [7:0] e);
        tick();
        q.push_back('{tag: tag, is_rd: 1'b0, exp: {24'd0, e}});
    endtask

    task automatic exp_rd(input string tag, input logic [1:0] a, input logic [31:0] e);
        tick();
        rd_en = 1'b1; addr = a;
        q.push_back('{tag: tag, is_rd: 1'b1, exp: e});
    endtask

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R2: reset state
        exp_irq("R2 irq after reset", 8'h00);
        exp_rd("R2 status after reset", 2'd3, 32'h0);
        exp_rd("R2 fall mask after reset", 2'd2, 32'h0);
        // R12: configure, channels 4-7 level
        wr(2'd0, 32'hFFFF_FFF0 & 32'h0000_00F0);
        wr(2'd1, 32'h0000_0055);
        wr(2'd2, 32'h0000_0006);
        exp_rd("R12 mode readback", 2'd0, 32'h0000_00F0);
        exp_rd("R12 rise readback", 2'd1, 32'h0000_0055);
        // R10: ch4, ch6 active-low and pins low
        exp_irq("R10 level live", 8'h50);
        // R3: ch0 rising
        set_pins(8'h01);
        exp_irq("R3 rising recorded", 8'h51);
        // R5: ch1 rise not enabled
        set_pins(8'h03);
        exp_irq("R5 disabled rise ignored", 8'h51);
        // R4: ch1 falling
        set_pins(8'h01);
        exp_irq("R4 falling recorded", 8'h53);
        // R5: ch3 transitions with no enable, then enable
        set_pins(8'h09);
        set_pins(8'h01);
        wr(2'd1, 32'h0000_005D);
        exp_irq("R5 late enable raises nothing", 8'h53);
        // R6: ch0 pin returns low, request stays
        set_pins(8'h00);
        exp_irq("R6 sticky", 8'h53);
        // R1: status read
        exp_rd("R1 status read", 2'd3, 32'h0000_0053);
        // R8: zero write
        wr(2'd3, 32'h0000_0000);
        exp_irq("R8 zero write irq", 8'h53);
        exp_rd("R8 zero write fall mask", 2'd2, 32'h0000_0006);
        // R7: acknowledge ch0 then ch1
        wr(2'd3, 32'h0000_0001);
        exp_irq("R7 ack ch0", 8'h52);
        wr(2'd3, 32'h0000_0002);
        exp_irq("R7 ack ch1", 8'h50);
        // R9: level flip ch4
        wr(2'd3, 32'h0000_0010);
        exp_irq("R9 flip drops ch4", 8'h40);
        exp_rd("R9 fall mask flipped", 2'd2, 32'h0000_0016);
        // R10: pin4 high now matches
        set_pins(8'h10);
        exp_irq("R10 level follows pin", 8'h50);
        // R11: ch2 rise, then fall with same-cycle ack
        set_pins(8'h14);
        exp_irq("R3 ch2 rise", 8'h54);
        tick();
        pin_in = 8'h10; wr_en = 1'b1; addr = 2'd3; wdata = 32'h0000_0004;
        exp_irq("R11 edge beats ack", 8'h54);
        wr(2'd3, 32'h0000_0004);
        exp_irq("R7 ack ch2", 8'h50);
        // R9: flip ch6 polarity
        wr(2'd3, 32'h0000_0040);
        exp_irq("R9 flip ch6", 8'h10);
        exp_rd("R1 status after flips", 2'd3, 32'h0000_0010);
        tick();
        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule